// File: doc/BRIEF.md
# Byte-Serial Carry-Less Multiplier Coprocessor

This block sits beside a small 8-bit processor. It speeds up multiplication in binary extension fields. The processor loads two N-bit operands a byte at a time. It then issues a capture access, which latches their full 2N-bit carry-less product (a polynomial product over GF(2)). After that the processor pulls the product back a byte at a time. Reduction by the field polynomial is left to software.

There is no control register. Every command comes from a strobed access, which is a read or write enable, together with one of sixteen select lines. Select 0 shifts a write byte into operand A and shifts a result byte out on a read. Select 4 shifts a write byte into operand B. Select 8 captures the product on any access. Select 15 clears all registers on any access. The operand width is a parameter and must be a multiple of 8. Inside, the product comes from a combinational multiplier, built either as one Karatsuba split or as a plain partial-product array.

Top module: `gf2_bytemul_cop`

## Requirements
- R1: While rst_n is low at a rising clock edge, operands A and B and the result register are cleared, so rdata reads 0x00 and a later capture yields an all-zero product.
- R2: A write strobe with sel[0] high (and neither sel[8] nor sel[15]) shifts operand A up by 8 bits and places wdata in bits [7:0]. After N/8 such writes, the first byte written occupies the top byte.
- R3: A write strobe with sel[4] high (and neither sel[8] nor sel[15]) shifts wdata into operand B the same way as R2.
- R4: A read or a write strobe with sel[8] high (and sel[15] low) loads the 2N-bit product of A and B into the result register. The value on wdata has no effect.
- R5: rdata always shows result bits [7:0]. A read strobe with sel[0] high (and neither sel[8] nor sel[15]) shifts the result right by 8 and fills zeros at the top, so 2N/8 reads return the product least significant byte first and later reads return 0x00.
- R6: A read or a write strobe with sel[15] high clears A, B and the result in the next cycle.
- R7: sel[15] overrides all other select lines. sel[8] overrides sel[0] and sel[4], so in that case A, B and the read position are left unchanged.
- R8: Select lines raised while both rd_en and wr_en are low have no effect.
- R9: The product is carry-less: each coefficient bit is the XOR of the AND terms a[i]&b[j] with i+j equal to that bit index. For example, 0x0A times 0x07 gives 0x36.
- R10: A strobed access in which none of sel[0], sel[4], sel[8] and sel[15] is high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| sel | input | 16 | I/O select lines |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Low byte of the result register |

## Verification
The bench aims at the priority corners. These are a capture raised together with operand selects, and a clear raised together with a capture. A design that let both act would corrupt an operand or keep stale product bytes. It checks that the shift direction leaves the first written byte on top. A reversed shift would scramble the product while the byte count stayed correct. It reads past the end of the result to catch wrap-around or a missing zero fill. It also drives unstrobed selects and strobes that raise no decoded line, which a loose decode would treat as commands. A small known product and a series of pseudo-random operands show whether the multiplier carries between coefficient bits.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 16;
  localparam int SEL_OPA = 0;
  localparam int SEL_OPB = 4;
  localparam int SEL_CAP = 8;
  localparam int SEL_CLR = 15;
  localparam logic [SEL_W-1:0] SEL_USED =
    (SEL_W'(1) << SEL_OPA) | (SEL_W'(1) << SEL_OPB) |
    (SEL_W'(1) << SEL_CAP) | (SEL_W'(1) << SEL_CLR);

  typedef struct packed {
    logic clear;
    logic capture;
    logic shift_a;
    logic shift_b;
    logic shift_r;
  } cmd_t;
endpackage

// File: rtl/gfm_sel_decode.sv
module gfm_sel_decode
  import gfm_pkg::*;
(
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  output cmd_t             cmd,
  output logic             foreign_only
);
  logic access;
  logic plain;

  always_comb begin
    access        = rd_en | wr_en;
    plain         = !sel[SEL_CLR] && !sel[SEL_CAP];
    cmd.clear     = access && sel[SEL_CLR];
    cmd.capture   = access && sel[SEL_CAP] && !sel[SEL_CLR];
    cmd.shift_a   = wr_en && sel[SEL_OPA] && plain;
    cmd.shift_b   = wr_en && sel[SEL_OPB] && plain;
    cmd.shift_r   = rd_en && sel[SEL_OPA] && plain;
    foreign_only  = access && ((sel & SEL_USED) == '0);
  end

  // R7: clear, capture and byte shifting are mutually exclusive modes
  always_comb begin
    a_r7_mode_exclusive: assert ($onehot0({cmd.clear, cmd.capture,
                                 (cmd.shift_a | cmd.shift_b | cmd.shift_r)}));
  end
endmodule

// File: rtl/gfm_byte_shreg.sv
module gfm_byte_shreg
  import gfm_pkg::*;
#(
  parameter int W      = 32,
  parameter bit UPWARD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic [W-1:0]      q
);
  logic [W-1:0] nxt;

  generate
    if (UPWARD) begin : g_up
      always_comb nxt = {q[W-BYTE_W-1:0], din};
    end else begin : g_down
      always_comb nxt = {din, q[W-1:BYTE_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   q <= '0;
    else if (load)       q <= load_val;
    else if (shift)      q <= nxt;
  end

  generate
    if (UPWARD) begin : g_chk_up
      // R2: new byte enters low, older contents move up
      a_r2_byte_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr && !load) |=>
          (q[BYTE_W-1:0] == $past(din)) &&
          (q[W-1:BYTE_W] == $past(q[W-BYTE_W-1:0])));
    end else begin : g_chk_down
      // R5: shift right by one byte with the supplied fill at the top
      a_r5_byte_leaves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr && !load) |=>
          (q[W-BYTE_W-1:0] == $past(q[W-1:BYTE_W])) &&
          (q[W-1:W-BYTE_W] == $past(din)));
    end
  endgenerate
endmodule

// File: rtl/gfm_clmul_school.sv
module gfm_clmul_school #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  function automatic logic [2*W-1:0] clmul_f(input logic [W-1:0] x,
                                             input logic [W-1:0] y);
    logic [2*W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        acc[i+j] = acc[i+j] ^ (x[i] & y[j]);
    return acc;
  endfunction

  always_comb p = clmul_f(a, b);
endmodule

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int W         = 32,
  parameter bit KARATSUBA = 1'b1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (KARATSUBA) begin : g_kara
      logic [W-1:0] t_hi, t_mix, t_lo, t_mid;
      logic [H-1:0] a_sum, b_sum;
      always_comb begin
        a_sum = a[W-1:H] ^ a[H-1:0];
        b_sum = b[W-1:H] ^ b[H-1:0];
      end
      gfm_clmul_school #(.W(H)) u_hi  (.a(a[W-1:H]), .b(b[W-1:H]), .p(t_hi));
      gfm_clmul_school #(.W(H)) u_mix (.a(a_sum),    .b(b_sum),    .p(t_mix));
      gfm_clmul_school #(.W(H)) u_lo  (.a(a[H-1:0]), .b(b[H-1:0]), .p(t_lo));
      always_comb begin
        t_mid = t_hi ^ t_mix ^ t_lo;
        p = ((2*W)'(t_hi) << W) ^ ((2*W)'(t_mid) << H) ^ (2*W)'(t_lo);
      end
    end else begin : g_flat
      gfm_clmul_school #(.W(W)) u_flat (.a(a), .b(b), .p(p));
    end
  endgenerate

  // R9: multiplying by the unit polynomial returns the other operand
  always_comb begin
    if (b == W'(1))
      a_r9_unit_operand: assert (p == (2*W)'(a));
  end
endmodule

// File: rtl/gf2_bytemul_cop.sv
module gf2_bytemul_cop
  import gfm_pkg::*;
#(
  parameter int OP_W      = 32,
  parameter bit KARATSUBA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int RES_W = 2 * OP_W;

  cmd_t             cmd;
  logic             foreign_only;
  logic [OP_W-1:0]  opa_q, opb_q;
  logic [RES_W-1:0] prod, res_q;

  gfm_sel_decode u_dec (
    .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
    .cmd(cmd), .foreign_only(foreign_only)
  );

  gfm_byte_shreg #(.W(OP_W), .UPWARD(1'b1)) u_opa (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clear), .load(1'b0),
    .load_val('0), .shift(cmd.shift_a), .din(wdata), .q(opa_q)
  );

  gfm_byte_shreg #(.W(OP_W), .UPWARD(1'b1)) u_opb (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clear), .load(1'b0),
    .load_val('0), .shift(cmd.shift_b), .din(wdata), .q(opb_q)
  );

  gfm_clmul #(.W(OP_W), .KARATSUBA(KARATSUBA)) u_mul (
    .a(opa_q), .b(opb_q), .p(prod)
  );

  gfm_byte_shreg #(.W(RES_W), .UPWARD(1'b0)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(cmd.clear), .load(cmd.capture),
    .load_val(prod), .shift(cmd.shift_r), .din('0), .q(res_q)
  );

  assign rdata = res_q[BYTE_W-1:0];

  // R1: reset clears every register
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (opa_q == '0) && (opb_q == '0) && (res_q == '0));

  // R6: clear access empties all state
  a_r6_clear_access: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && sel[SEL_CLR]) |=>
      (opa_q == '0) && (opb_q == '0) && (rdata == '0));

  // R4, R7: capture loads the product and leaves operands untouched
  a_r4_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && sel[SEL_CAP] && !sel[SEL_CLR]) |=>
      (res_q == $past(prod)) && $stable(opa_q) && $stable(opb_q));

  // R8: no strobe, no change
  a_r8_unstrobed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> $stable(opa_q) && $stable(opb_q) && $stable(res_q));

  // R10: undecoded select lines are inert
  a_r10_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_only |=> $stable(opa_q) && $stable(opb_q) && $stable(res_q));
endmodule

// File: tb/gf2_bytemul_cop_tb.sv
module gf2_bytemul_cop_tb;
  localparam int N  = 32;
  localparam int NB = N / 8;
  localparam int RB = 2 * N / 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] sel = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0]   m_a = '0, m_b = '0;
  logic [2*N-1:0] m_r = '0;
  logic [7:0]     exp_q[$];
  string          tag_q[$];

  always #2 clk = ~clk;

  gf2_bytemul_cop #(.OP_W(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .sel(sel), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] acc, sh;
    acc = '0;
    sh  = (2*N)'(a);
    for (int k = 0; k < N; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rd, input logic wr, input logic [15:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    rd_en = rd; wr_en = wr; sel = s; wdata = d;
  endtask

  task automatic settle();
    bus(1'b0, 1'b0, 16'h0000, 8'h00);
    @(negedge clk);
  endtask

  task automatic wr_a(input logic [7:0] d);
    m_a = {m_a[N-9:0], d};
    bus(1'b0, 1'b1, 16'h0001, d);
  endtask

  task automatic wr_b(input logic [7:0] d);
    m_b = {m_b[N-9:0], d};
    bus(1'b0, 1'b1, 16'h0010, d);
  endtask

  task automatic capture(input logic via_read, input logic [15:0] extra, input logic [7:0] junk);
    m_r = ref_mul(m_a, m_b);
    bus(via_read, !via_read, 16'h0100 | extra, junk);
  endtask

  task automatic rd_byte(input string tag);
    exp_q.push_back(m_r[7:0]);
    tag_q.push_back(tag);
    m_r = m_r >> 8;
    bus(1'b1, 1'b0, 16'h0001, 8'h00);
  endtask

  task automatic rd_all(input string tag);
    for (int k = 0; k < RB; k++) rd_byte(tag);
  endtask

  task automatic clear_model();
    m_a = '0; m_b = '0; m_r = '0;
  endtask

  // monitor: scoreboard pops one expected byte per result read
  always @(negedge clk) begin
    if (rst_n && rd_en && sel[0] && !sel[8] && !sel[15]) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected read", {56'h0, rdata}, 64'hFFFF);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {56'h0, rdata}, {56'h0, e});
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] lf;
    logic [7:0]  hold;
    lf = 32'h1D2C_3B4A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", {56'h0, rdata}, 64'h0);
    capture(1'b0, 16'h0, 8'h00);
    rd_all("R1 zero product after reset");

    // main pattern, capture by write with nonzero data
    wr_a(8'h12); wr_a(8'h34); wr_a(8'h56); wr_a(8'h78);
    wr_b(8'h9A); wr_b(8'hBC); wr_b(8'hDE); wr_b(8'hF0);
    capture(1'b0, 16'h0, 8'hFF);
    rd_all("R2 R3 R4 R9 main product");
    rd_byte("R5 zero fill after drain");
    settle();
    chk("R5 rdata after drain", {56'h0, rdata}, 64'h0);

    // clear then small known product, captured via read
    bus(1'b1, 1'b0, 16'h8000, 8'h00); clear_model();
    settle();
    chk("R6 clear by read", {56'h0, rdata}, 64'h0);
    wr_a(8'h0A); wr_b(8'h07);
    capture(1'b1, 16'h0, 8'h00);
    settle();
    chk("R9 0x0A*0x07", {56'h0, rdata}, 64'h36);
    chk("R4 read capture model", {56'h0, rdata}, {56'h0, m_r[7:0]});
    rd_all("R4 read capture bytes");

    // capture raised with operand selects: operands must hold
    wr_a(8'hC3); wr_b(8'h5A);
    capture(1'b0, 16'h0011, 8'hEE);
    rd_all("R7 capture over A/B selects");
    capture(1'b1, 16'h0001, 8'h00);
    rd_byte("R7 capture over read shift");
    capture(1'b0, 16'h0, 8'h00);
    rd_all("R7 operands unchanged check");

    // unstrobed selects and foreign lines
    capture(1'b0, 16'h0, 8'h00);
    settle();
    hold = rdata;
    bus(1'b0, 1'b0, 16'h8111, 8'hAA);
    settle();
    chk("R8 unstrobed selects", {56'h0, rdata}, {56'h0, hold});
    bus(1'b1, 1'b1, 16'h7EEE, 8'h55);
    settle();
    chk("R10 foreign select lines", {56'h0, rdata}, {56'h0, hold});
    rd_all("R8 R10 state kept");

    // clear beats capture and operand shift
    capture(1'b0, 16'h0, 8'h00);
    bus(1'b0, 1'b1, 16'h8111, 8'h77); clear_model();
    settle();
    chk("R7 clear priority rdata", {56'h0, rdata}, 64'h0);
    capture(1'b1, 16'h0, 8'h00);
    rd_all("R6 operands cleared");

    // partial load: first byte not yet on top
    wr_a(8'h81); wr_a(8'h42);
    wr_b(8'hFF); wr_b(8'hFF); wr_b(8'hFF); wr_b(8'hFF);
    capture(1'b0, 16'h0, 8'h00);
    rd_all("R2 partial operand load");

    // pseudo-random patterns
    for (int it = 0; it < 8; it++) begin
      for (int k = 0; k < NB; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        wr_a(lf[7:0]);
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        wr_b(lf[15:8]);
      end
      capture(it[0], 16'h0, lf[23:16]);
      rd_all("R9 random product");
    end

    settle();
    chk("R5 scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    summary();
  end
endmodule